// File: doc/BRIEF.md
# Two-Slot Elastic Buffer with Valid/Stop Handshake

This block sits between a producer and a consumer and separates them in time. Both sides use the same handshake. A forward `valid` qualifies `data`, and a backward `stop` asks the sender to hold its item. Accepted items are held in a small ring of slots, each with its own occupancy flag. Items leave in arrival order. Backpressure reaches the producer only when every slot is occupied and the consumer is stalling. A chain of these buffers therefore stalls one hop at a time, with no central stall controller.

Each of the two channels has a monitor. Every cycle it classifies the channel as idle, retry or transfer. It also flags a sender that breaks the retry rule: after a retry cycle, the sender must repeat the same item, still valid, until it is taken.

Top module: `elastic_buf2`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released: out_valid_o is 0, in_stop_o is 0, both error outputs are 0, and out_state_o is IDLE.
- R2: An item accepted in cycle t (in_valid_i high, in_stop_o low) while the buffer is empty is on out_data_o with out_valid_o high in cycle t+1.
- R3: Items leave in the order they were accepted, each exactly once, with no loss and no duplication.
- R4: in_stop_o is high exactly when all DEPTH slots are occupied and out_stop_i is high.
- R5: When out_valid_o is high and out_stop_i is high, the next cycle has out_valid_o high and the same out_data_o, so out_err_o never rises.
- R6: An item offered while in_stop_o is high is not stored. It is taken only in a later cycle in which in_stop_o is low.
- R7: With out_stop_i held low and the producer valid every cycle, one item passes per cycle, out_valid_o stays high from the second cycle on, and in_stop_o stays low.
- R8: Each channel state output is encoded as follows: 0 (IDLE) when that channel's valid is low, 1 (RETRY) when valid and stop are both high, 2 (TRANSFER) when valid is high and stop is low.
- R9: in_err_o is high in a cycle exactly when the previous cycle on the input channel was RETRY and, in this cycle, in_valid_i is low or in_data_i differs from the previous cycle's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | DATA_W | Producer data |
| in_valid_i | input | 1 | Producer data valid |
| in_stop_o | output | 1 | Backpressure to producer |
| out_data_o | output | DATA_W | Data to consumer, oldest stored item |
| out_valid_o | output | 1 | Consumer data valid |
| out_stop_i | input | 1 | Backpressure from consumer |
| in_state_o | output | 2 | Input channel state (0 idle, 1 retry, 2 transfer) |
| out_state_o | output | 2 | Output channel state (0 idle, 1 retry, 2 transfer) |
| in_err_o | output | 1 | Producer broke the retry rule this cycle |
| out_err_o | output | 1 | Output channel broke the retry rule this cycle |

## Verification
The stop, state and error outputs are combinational on the current inputs and the stored state, so they are due in the same cycle as the inputs they depend on. An accepted item shows up on the output one clock edge after its acceptance, and a pop frees its slot at that same edge. The bench drives inputs just after the falling edge and compares all outputs with a queue-based model shortly afterwards. At the rising edge it advances the model using the values it has just checked. Because of this ordering, every comparison falls in the cycle in which the result is due.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RETRY = 2'd1,
    CH_XFER  = 2'd2
  } chan_st_e;
endpackage

// File: rtl/ebuf_slots.sv
module ebuf_slots #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_valid_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [DATA_W-1:0] slot_vec [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // pop before push: when full, the freed slot is the one refilled
  always_comb begin
    vld_d = vld_q;
    if (pop_i)  vld_d[rd_q] = 1'b0;
    if (push_i) vld_d[wr_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q <= '0;
      else if (push_i && wr_q == PTR_W'(g))     slot_q <= push_data_i;
    end
    assign slot_vec[g] = slot_q;
  end

  assign head_data_o  = slot_vec[rd_q];
  assign head_valid_o = vld_q[rd_q];
  assign full_o       = &vld_q;
endmodule

// File: rtl/ebuf_chan_mon.sv
module ebuf_chan_mon
  import ebuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [1:0]        state_o,
  output logic              err_o
);
  chan_st_e          st;
  logic              pend_q;
  logic [DATA_W-1:0] held_q;

  always_comb begin
    if (!valid_i)    st = CH_IDLE;
    else if (stop_i) st = CH_RETRY;
    else             st = CH_XFER;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      held_q <= '0;
    end else begin
      pend_q <= (st == CH_RETRY);
      held_q <= data_i;
    end
  end

  assign state_o = st;
  assign err_o   = pend_q && (!valid_i || data_i != held_q);
endmodule

// File: rtl/elastic_buf2.sv
module elastic_buf2 #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_stop_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_stop_i,
  output logic [1:0]        in_state_o,
  output logic [1:0]        out_state_o,
  output logic              in_err_o,
  output logic              out_err_o
);
  logic full, push, pop;

  assign in_stop_o = full && out_stop_i;
  assign push      = in_valid_i && !in_stop_o;
  assign pop       = out_valid_o && !out_stop_i;

  ebuf_slots #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_slots (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_data_i  (in_data_i),
    .pop_i        (pop),
    .head_data_o  (out_data_o),
    .head_valid_o (out_valid_o),
    .full_o       (full)
  );

  ebuf_chan_mon #(.DATA_W(DATA_W)) u_mon_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .stop_i  (in_stop_o),
    .data_i  (in_data_i),
    .state_o (in_state_o),
    .err_o   (in_err_o)
  );

  ebuf_chan_mon #(.DATA_W(DATA_W)) u_mon_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (out_valid_o),
    .stop_i  (out_stop_i),
    .data_i  (out_data_o),
    .state_o (out_state_o),
    .err_o   (out_err_o)
  );
endmodule

// File: rtl/elastic_buf2_chk.sv
module elastic_buf2_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_valid_i,
  input logic              in_stop_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_valid_o,
  input logic              out_stop_i,
  input logic [1:0]        in_state_o,
  input logic [1:0]        out_state_o,
  input logic              in_err_o,
  input logic              out_err_o
);
  AST_STOP_NEEDS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_stop_o |-> (out_stop_i && out_valid_o)); // R4

  AST_EMPTY_ACCEPT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_stop_o && !out_valid_o) |=>
      (out_valid_o && out_data_o == $past(in_data_i))); // R2

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_stop_i) |=> (out_valid_o && $stable(out_data_o))); // R5

  AST_OUT_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_err_o); // R5

  AST_IN_XFER_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_stop_o) |-> in_state_o == 2'd2); // R8

  AST_OUT_RETRY_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_stop_i) |-> out_state_o == 2'd1); // R8

  AST_ERR_AFTER_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_err_o |-> $past(in_valid_i && in_stop_o)); // R9
endmodule

bind elastic_buf2 elastic_buf2_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_data_i   (in_data_i),
  .in_valid_i  (in_valid_i),
  .in_stop_o   (in_stop_o),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_stop_i  (out_stop_i),
  .in_state_o  (in_state_o),
  .out_state_o (out_state_o),
  .in_err_o    (in_err_o),
  .out_err_o   (out_err_o)
);

// File: tb/sim_elastic_buf2.sv
`timescale 1ns/1ps
module sim_elastic_buf2;
  localparam int DW = 16;
  localparam int DEPTH = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          out_stop = 1'b0;
  logic          in_stop, out_valid, in_err, out_err;
  logic [DW-1:0] out_data;
  logic [1:0]    in_state, out_state;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  elastic_buf2 #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_stop_o(in_stop), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_stop_i(out_stop), .in_state_o(in_state), .out_state_o(out_state),
    .in_err_o(in_err), .out_err_o(out_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, act, exp);
    end
  endtask

  function automatic int code(input logic v, input logic s);
    return !v ? 0 : (s ? 1 : 2);
  endfunction

  // reference model
  logic [DW-1:0] q[$];
  logic          pend = 1'b0;
  logic [DW-1:0] held = '0;
  logic [DW-1:0] next_val = 16'h0100;

  task automatic run_phase(input int cycles, input int vprob, input int sprob,
                           input bit obey, input bit stream);
    for (int c = 0; c < cycles; c++) begin
      logic ev, es, ee, last_retry;
      @(negedge clk);
      last_retry = pend;
      out_stop = ($urandom_range(99) < sprob);
      if (last_retry && obey) begin
        // hold item as the rule requires
      end else if (last_retry && $urandom_range(1) == 1) begin
        if ($urandom_range(1) == 1) in_valid = 1'b0;
        else in_data = in_data ^ 16'h0001;
      end else begin
        in_valid = ($urandom_range(99) < vprob);
        if (in_valid) begin
          in_data = next_val;
          next_val = next_val + 1'b1;
        end
      end
      #1;
      ev = (q.size() > 0);
      es = (q.size() == DEPTH) && out_stop;
      ee = pend && (!in_valid || in_data != held);
      chk("R2 R3", "out_valid", out_valid, ev);
      if (ev) chk("R3 R5", "out_data", out_data, q[0]);
      chk("R4 R6", "in_stop", in_stop, es);
      chk("R8", "in_state", in_state, code(in_valid, es));
      chk("R8", "out_state", out_state, code(ev, out_stop));
      chk("R9", "in_err", in_err, ee);
      chk("R5", "out_err", out_err, 0);
      if (stream && c > 0) begin
        chk("R7", "stream out_valid", out_valid, 1);
        chk("R7", "stream in_stop", in_stop, 0);
      end
      @(posedge clk);
      if (ev && !out_stop) void'(q.pop_front());
      if (in_valid && !es) q.push_back(in_data);
      pend = in_valid && es;
      held = in_data;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "rst out_valid", out_valid, 0);
    chk("R1", "rst in_stop", in_stop, 0);
    chk("R1", "rst in_err", in_err, 0);
    chk("R1", "rst out_err", out_err, 0);
    chk("R1", "rst out_state", out_state, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1", "post-rst out_valid", out_valid, 0);
    chk("R1", "post-rst in_stop", in_stop, 0);
    run_phase(60, 100, 0, 1'b1, 1'b1);   // streaming
    run_phase(20, 100, 100, 1'b1, 1'b0); // fill and stall
    run_phase(20, 0, 0, 1'b1, 1'b0);     // drain
    run_phase(600, 60, 40, 1'b1, 1'b0);  // random, rule kept
    run_phase(400, 70, 60, 1'b0, 1'b0);  // random, rule broken
    run_phase(10, 0, 0, 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule